// File: doc/BRIEF.md
# Overlapping Pulse-Position Packet Encoder

This block turns fixed-width data packets into a single-bit pulse train that drives an optical or GPIO transmitter. Time is divided into slots of a fixed number of clock ticks, and exactly one pulse is emitted per slot. The packet is cut into symbols of a few bits each, taken most-significant group first. Each symbol picks where its pulse starts inside its slot: the start offset is the symbol value times a position step. The pulse may be wider than the step, so pulses for neighbouring values overlap in time. This overlapping arrangement lets a slow analog channel carry several bits per pulse.

Every packet is led by a fixed number of preamble pulses that all carry the value zero, so each of them starts on a slot boundary. A receiver uses them to find the start of the packet and to measure the transmitter's edge offset. Packets enter through a valid/ready handshake. A packet is accepted on any clock edge where both `in_valid` and `in_ready` are high. Back-pressure is applied by holding `in_ready` low for the whole transmission, except in its very last tick. In that tick a new packet can be accepted, and its preamble then follows with no idle gap. While `in_ready` is low, `in_valid` and `in_data` are ignored and may change freely. The widths and counts are all parameters: pulse width, slot width and position step in ticks, bits per symbol, packet width and preamble length.

Top module: `oppm_encoder`

## Requirements
- R1: When no transmission is in progress, `in_ready` is high, and a packet is accepted on a rising clock edge with `in_valid` and `in_ready` both high.
- R2: From the acceptance edge, `in_ready` stays low until the final tick of the last data slot. It is high during that tick.
- R3: `busy` is high for exactly (PRE_N + PKT_W/SYM_BITS) * SLOT_W cycles, starting with the cycle after acceptance. It is low at all other times unless a new packet is chained.
- R4: The packet is sent as PKT_W/SYM_BITS symbols, one per slot. The first symbol is bits [PKT_W-1 -: SYM_BITS], and each later symbol is the next lower group of bits.
- R5: PRE_N preamble slots come before the data slots. Each preamble slot carries symbol value 0, so its pulse occupies ticks 0 to PULSE_W-1 of the slot.
- R6: In a data slot with symbol value v, `tx_out` is high exactly in ticks v*POS_STEP up to v*POS_STEP+PULSE_W-1 of that slot. Tick 0 of the first slot is the cycle right after acceptance.
- R7: `tx_out` is low whenever `busy` is low, and low in every tick of a slot outside its pulse.
- R8: A pulse width larger than the position step is supported, so the pulses of neighbouring values overlap, and the timing of R6 still holds.
- R9: Changes on `in_valid` and `in_data` during a transmission, other than in its final tick, have no effect on `tx_out`, `busy` or `in_ready`.
- R10: A packet accepted in the final tick of a transmission starts its first preamble pulse in the next cycle, with `busy` staying high.
- R11: A configuration where (2^SYM_BITS-1)*POS_STEP + PULSE_W exceeds SLOT_W, or where PKT_W is not a multiple of SYM_BITS, is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Packet offered on `in_data` |
| in_ready | output | 1 | Encoder can take a packet this cycle |
| in_data | input | PKT_W | Packet bits, most significant group sent first |
| tx_out | output | 1 | Pulse stream to the transmitter |
| busy | output | 1 | Preamble or data being sent |

## Verification
On every cycle, the bound checker asserts the handshake and idle rules. It checks that `in_ready` is high when idle, that `tx_out` is quiet when idle, that `in_ready` drops after a fresh acceptance, and that the first preamble pulse follows acceptance. It also counts `busy` cycles so that the transmission length of R3 is checked. The exact pulse positions for each symbol (R4, R6, R8) can only be shown by the bench scenarios, which compare every tick against a model of the slot timing. The same holds for the insensitivity to input changes mid-packet (R9) and for gap-free chaining (R10). The bench uses an overlapping configuration with a pulse 3 ticks wide, a step of 1 tick and 6-tick slots.

// File: rtl/oppm_pkg.sv
package oppm_pkg;
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/oppm_slot_timer.sv
module oppm_slot_timer #(
  parameter int SLOT_W = 4,
  parameter int PRE_N  = 3,
  parameter int TOT    = 7,
  localparam int TW    = oppm_pkg::cnt_width(SLOT_W),
  localparam int SW    = oppm_pkg::cnt_width(TOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic [TW-1:0] tick_o,
  output logic          busy_o,
  output logic          in_pre_o,
  output logic          slot_end_o,
  output logic          done_o
);
  logic [SW-1:0] slot_q;
  logic [TW-1:0] tick_q;
  logic          busy_q;

  assign slot_end_o = busy_q && (tick_q == TW'(SLOT_W - 1));
  assign done_o     = slot_end_o && (slot_q == SW'(TOT - 1));
  assign in_pre_o   = slot_q < SW'(PRE_N);
  assign tick_o     = tick_q;
  assign busy_o     = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      slot_q <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      tick_q <= '0;
      slot_q <= '0;
      busy_q <= 1'b1;
    end else if (done_o) begin
      tick_q <= '0;
      slot_q <= '0;
      busy_q <= 1'b0;
    end else if (slot_end_o) begin
      tick_q <= '0;
      slot_q <= slot_q + 1'b1;
    end else if (busy_q) begin
      tick_q <= tick_q + 1'b1;
    end
  end
endmodule

// File: rtl/oppm_symbol_shifter.sv
module oppm_symbol_shifter #(
  parameter int PKT_W    = 8,
  parameter int SYM_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [PKT_W-1:0]    data_i,
  input  logic                in_pre_i,
  input  logic                slot_end_i,
  output logic [SYM_BITS-1:0] sym_o
);
  logic [PKT_W-1:0] sh_q;

  assign sym_o = in_pre_i ? '0 : sh_q[PKT_W-1 -: SYM_BITS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sh_q <= '0;
    else if (load_i)
      sh_q <= data_i;
    else if (slot_end_i && !in_pre_i)
      sh_q <= sh_q << SYM_BITS;
  end
endmodule

// File: rtl/oppm_pulse_shaper.sv
module oppm_pulse_shaper #(
  parameter int SYM_BITS = 2,
  parameter int POS_STEP = 1,
  parameter int PULSE_W  = 1,
  parameter int TW       = 2
) (
  input  logic                busy_i,
  input  logic [TW-1:0]       tick_i,
  input  logic [SYM_BITS-1:0] sym_i,
  output logic                pulse_o
);
  logic [31:0] off, tk;

  always_comb begin
    tk      = 32'(tick_i);
    off     = 32'(sym_i) * 32'(POS_STEP);
    pulse_o = busy_i && (tk >= off) && (tk < off + 32'(PULSE_W));
  end
endmodule

// File: rtl/oppm_encoder.sv
module oppm_encoder #(
  parameter int PULSE_W  = 1,
  parameter int SLOT_W   = 4,
  parameter int POS_STEP = 1,
  parameter int SYM_BITS = 2,
  parameter int PKT_W    = 8,
  parameter int PRE_N    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PKT_W-1:0] in_data,
  output logic             tx_out,
  output logic             busy
);
  localparam int NUM_SYM = PKT_W / SYM_BITS;
  localparam int TOT     = PRE_N + NUM_SYM;
  localparam int TW      = oppm_pkg::cnt_width(SLOT_W);
  localparam int MAX_END = ((1 << SYM_BITS) - 1) * POS_STEP + PULSE_W;

  // R11: the latest pulse must end inside its slot; symbols must tile the packet
  if (MAX_END > SLOT_W || (PKT_W % SYM_BITS) != 0 || PRE_N < 1) begin : g_bad_cfg
    $error("oppm_encoder: pulse does not fit its slot or packet not divisible");
  end

  logic          accept, in_pre, slot_end, done;
  logic [TW-1:0] tick;
  logic [SYM_BITS-1:0] sym;

  assign in_ready = !busy || done;
  assign accept   = in_valid && in_ready;

  oppm_slot_timer #(.SLOT_W(SLOT_W), .PRE_N(PRE_N), .TOT(TOT)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(accept), .tick_o(tick),
    .busy_o(busy), .in_pre_o(in_pre), .slot_end_o(slot_end), .done_o(done)
  );

  oppm_symbol_shifter #(.PKT_W(PKT_W), .SYM_BITS(SYM_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .data_i(in_data),
    .in_pre_i(in_pre), .slot_end_i(slot_end), .sym_o(sym)
  );

  oppm_pulse_shaper #(.SYM_BITS(SYM_BITS), .POS_STEP(POS_STEP),
                      .PULSE_W(PULSE_W), .TW(TW)) u_shape (
    .busy_i(busy), .tick_i(tick), .sym_i(sym), .pulse_o(tx_out)
  );
endmodule

// File: rtl/oppm_encoder_chk.sv
module oppm_encoder_chk #(
  parameter int TOTC = 28
) (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic tx_out,
  input logic busy
);
  logic acc;
  int   bcnt;
  assign acc = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bcnt <= 0;
    else if (acc)  bcnt <= 0;
    else if (busy) bcnt <= bcnt + 1;
  end

  p_idle_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> in_ready);
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !busy) |=> !in_ready);
  p_accept_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> busy);
  p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bcnt == TOTC);
  p_busy_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> bcnt < TOTC);
  p_first_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> tx_out);
  p_quiet_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_out);
endmodule

bind oppm_encoder oppm_encoder_chk #(
  .TOTC((PRE_N + PKT_W / SYM_BITS) * SLOT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .tx_out(tx_out), .busy(busy)
);

// File: tb/oppm_encoder_tb_top.sv
module oppm_encoder_tb_top;
  // R8: overlapping configuration, pulse 3 ticks wide, step 1 tick
  localparam int PW = 3, SLOT = 6, STEP = 1, SB = 2, PKT = 8, PRE = 3;
  localparam int TOTC = (PRE + PKT / SB) * SLOT;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [PKT-1:0] in_data = '0;
  logic in_ready, tx_out, busy;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  oppm_encoder #(.PULSE_W(PW), .SLOT_W(SLOT), .POS_STEP(STEP), .SYM_BITS(SB),
                 .PKT_W(PKT), .PRE_N(PRE)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .tx_out(tx_out), .busy(busy)
  );

  function automatic bit exp_tx(input logic [PKT-1:0] d, input int k);
    int s = k / SLOT, t = k % SLOT, sym = 0, off;
    if (s >= PRE) sym = int'((d >> (PKT - SB * (s - PRE + 1))) & ((1 << SB) - 1));
    off = sym * STEP;
    return (t >= off) && (t < off + PW);
  endfunction

  task automatic chk(input bit got, input bit exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0b exp=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic offer(input logic [PKT-1:0] d);
    in_valid = 1'b1;
    in_data  = d;
    chk(in_ready, 1'b1, "R1 ready before accept");
    @(negedge clk);
  endtask

  // one full transmission; junk = R9 input noise; chain = R10 next packet
  task automatic run_pkt(input logic [PKT-1:0] d, input bit junk,
                         input bit chain, input logic [PKT-1:0] nd);
    for (int k = 0; k < TOTC; k++) begin
      if (k == TOTC - 1) begin
        in_valid = chain;
        in_data  = nd;
      end else if (junk) begin
        in_valid = 1'($urandom % 2);
        in_data  = PKT'($urandom);
      end else begin
        in_valid = 1'b0;
      end
      chk(tx_out, exp_tx(d, k), (k < PRE * SLOT) ? "R5 preamble" : "R6/R4 data pulse");
      chk(busy, 1'b1, "R3 busy");
      chk(in_ready, k == TOTC - 1, "R2 ready");
      @(negedge clk);
    end
    if (!chain) begin
      in_valid = 1'b0;
      chk(busy, 1'b0, "R3 idle");
      chk(tx_out, 1'b0, "R7 idle");
      chk(in_ready, 1'b1, "R1 idle ready");
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: got=hang exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [PKT-1:0] cur, nxt;
    bit ch;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(in_ready, 1'b1, "R1 reset");
    chk(busy, 1'b0, "R3 reset");
    chk(tx_out, 1'b0, "R7 reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx_out, 1'b0, "R7 idle after reset");

    // directed: all-zero, all-max, ascending and descending symbol order
    offer(8'h00); run_pkt(8'h00, 1'b0, 1'b0, '0);
    offer(8'hFF); run_pkt(8'hFF, 1'b0, 1'b0, '0);
    offer(8'h1B); run_pkt(8'h1B, 1'b0, 1'b0, '0);
    offer(8'hE4); run_pkt(8'hE4, 1'b1, 1'b0, '0);
    // R10 back-to-back
    offer(8'hA5); run_pkt(8'hA5, 1'b0, 1'b1, 8'h3C);
    run_pkt(8'h3C, 1'b1, 1'b0, '0);

    // random packets with mid-packet noise (R9) and random chaining (R10)
    cur = PKT'($urandom);
    offer(cur);
    for (int i = 0; i < 12; i++) begin
      nxt = PKT'($urandom);
      ch  = (i != 11) && ($urandom % 2 == 1);
      run_pkt(cur, 1'b1, ch, nxt);
      if (!ch && i != 11) begin
        repeat ($urandom % 3) @(negedge clk);
        offer(nxt);
      end
      cur = nxt;
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule